// File: doc/BRIEF.md
# Clockwise Thermal Migration Pair Selector

This block sits beside the cores of an 8x8 mesh and decides, once per fixed interval, which tasks should change places to spread heat. No temperature sensors are used. Each core reports an activity count (instructions per cycle from its performance counter). Clock frequency and supply voltage are fixed, so power, and with it heat, is taken as proportional to that count. Reports may arrive at any time and are kept in a pending table. When an interval closes, the unit copies the pending table into a working table that does not change until the next evaluation.

The floorplan is split into a central square of 16 cores and a ring of 48 cores. The ring is cut into four pinwheel regions of 12 cores each, numbered clockwise. The unit takes the central cores one at a time, hottest first. It pairs each central core with the coldest still-unused core of the next ring region in clockwise turn. A swap command (central core, ring core) is emitted only when the central core sits in a strictly higher activity level than its partner. Commands leave on a valid/ready stream, one at a time.

Control is a four-state machine. IDLE waits for the end of an interval. IDLE→LOAD is taken on that event and copies the pending table. LOAD→PICK always follows. PICK selects a candidate pair: PICK→ISSUE when the pair qualifies, PICK→PICK for the next central core when it does not, and PICK→IDLE after the last central core is examined. ISSUE holds the command: ISSUE→PICK when it is accepted, ISSUE→IDLE when it was the last central core, and ISSUE→ISSUE while it waits.

Top module: `clockwise_mig_sel`

## Requirements
- R1: After reset `cmd_valid` and `overrun` are 0 and every pending activity value is 0, so an interval closed with no reports yields no command.
- R2: Core index is row*8+column. Central cores are rows 2..5 with columns 2..5. Ring region 0 is rows 0..1, columns 0..5. Region 1 is rows 0..5, columns 6..7. Region 2 is rows 6..7, columns 2..7. Region 3 is rows 2..7, columns 0..1. Every `cmd_src` is central and every `cmd_dst` is a ring core.
- R3: The activity level is 0 for values below 5, 1 for 5..9, 2 for 10..14, 3 for 15..19 and 4 for 20 and above.
- R4: Central cores are examined in descending activity order. Equal values are examined in ascending core index.
- R5: The k-th examined central core (k from 0) is offered the coldest unused core of region k mod 4, with ties going to the lowest index. The region advances whether or not a command results.
- R6: A command is emitted only when the central core's level is strictly greater than the level of its offered ring core.
- R7: Within one evaluation no core index appears in more than one command.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_src` and `cmd_dst` stay unchanged into the next cycle.
- R9: Reports written after an evaluation has started affect only later evaluations.
- R10: `interval_end` pulses for one cycle every INTERVAL cycles.
- R11: An `interval_end` that occurs while an evaluation is still in progress raises `overrun` for one cycle, and no new evaluation starts from that pulse.
- R12: Each evaluation examines exactly 16 central cores, so it yields at most 16 commands before returning to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_wr_en | input | 1 | Activity report strobe |
| act_wr_core | input | 6 | Core index of the report |
| act_wr_value | input | AW (8) | Reported activity count |
| interval_end | output | 1 | One-cycle pulse closing each interval |
| cmd_valid | output | 1 | Swap command present |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_src | output | 6 | Central core whose task moves out |
| cmd_dst | output | 6 | Ring core whose task moves in |
| overrun | output | 1 | Interval closed while the unit was busy |

## Verification
Two functions can meet in one cycle: the interval timer firing, and the command stream still holding an unaccepted swap. The bench provokes this by holding `cmd_ready` low until the interval closes again. During that stall it writes a fresh set of reports. It then checks four things: `overrun` pulses exactly once; the held command never changes; the remaining commands still follow the old reports; and the fresh reports drive the command list of the next evaluation.

// File: rtl/cms_pkg.sv
package cms_pkg;

    localparam int LVL_T1 = 5;
    localparam int LVL_T2 = 10;
    localparam int LVL_T3 = 15;
    localparam int LVL_T4 = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PICK,
        ST_ISSUE
    } cms_state_e;

    // Map an activity count onto its five-step level
    function automatic logic [2:0] cms_level(input logic [15:0] a);
        logic [2:0] l;
        l = 3'd0;
        if (a >= 16'(LVL_T1)) l = 3'd1;
        if (a >= 16'(LVL_T2)) l = 3'd2;
        if (a >= 16'(LVL_T3)) l = 3'd3;
        if (a >= 16'(LVL_T4)) l = 3'd4;
        return l;
    endfunction

    function automatic logic cms_is_central(input int idx, input int mesh);
        int b, r, c;
        b = mesh / 4;
        r = idx / mesh;
        c = idx % mesh;
        return (r >= b) && (r < mesh - b) && (c >= b) && (c < mesh - b);
    endfunction

    // Pinwheel split of the ring, numbered clockwise from the top
    function automatic logic [1:0] cms_region(input int idx, input int mesh);
        int b, r, c;
        b = mesh / 4;
        r = idx / mesh;
        c = idx % mesh;
        if (r < b && c < mesh - b)       return 2'd0;
        else if (c >= mesh - b && r < mesh - b) return 2'd1;
        else if (r >= mesh - b && c >= b) return 2'd2;
        else                             return 2'd3;
    endfunction

endpackage

// File: rtl/cms_timer.sv
module cms_timer #(
    parameter int INTERVAL = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(INTERVAL - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(INTERVAL - 1));

    generate
        if (INTERVAL > 1) begin : g_gap
            AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R10
        end
    endgenerate

endmodule

// File: rtl/cms_act_store.sv
module cms_act_store #(
    parameter int NCORE = 64,
    parameter int AW    = 8,
    parameter int IDXW  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [AW-1:0]             wr_val,
    input  logic                      load,
    output logic [NCORE-1:0][AW-1:0]  work
);
    logic [NCORE-1:0][AW-1:0] pend;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (wr_en)
            pend[wr_idx] <= wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            work <= '0;
        else if (load)
            work <= pend;
    end

    AST_WORK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(work)); // R9

endmodule

// File: rtl/cms_pick.sv
module cms_pick
    import cms_pkg::*;
#(
    parameter int MESH  = 8,
    parameter int NCORE = 64,
    parameter int AW    = 8,
    parameter int IDXW  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCORE-1:0][AW-1:0]  work,
    input  logic [NCORE-1:0]          used,
    input  logic [1:0]                region_sel,
    output logic [IDXW-1:0]           hot_idx,
    output logic                      hot_found,
    output logic [IDXW-1:0]           cold_idx,
    output logic                      cold_found
);
    logic [AW-1:0] hot_val;
    logic [AW-1:0] cold_val;

    // Hottest free central core, lowest index on ties
    always_comb begin
        hot_idx   = '0;
        hot_found = 1'b0;
        hot_val   = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (cms_is_central(i, MESH) && !used[i]
                && (!hot_found || work[i] > hot_val)) begin
                hot_idx   = IDXW'(i);
                hot_found = 1'b1;
                hot_val   = work[i];
            end
        end
    end

    // Coldest free core of the selected ring region, lowest index on ties
    always_comb begin
        cold_idx   = '0;
        cold_found = 1'b0;
        cold_val   = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (!cms_is_central(i, MESH) && (cms_region(i, MESH) == region_sel)
                && !used[i] && (!cold_found || work[i] < cold_val)) begin
                cold_idx   = IDXW'(i);
                cold_found = 1'b1;
                cold_val   = work[i];
            end
        end
    end

    AST_COLD_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        cold_found |-> (cms_region(int'(cold_idx), MESH) == region_sel)
                       && !cms_is_central(int'(cold_idx), MESH)); // R5

    AST_HOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        hot_found |-> !used[hot_idx]); // R7

endmodule

// File: rtl/clockwise_mig_sel.sv
module clockwise_mig_sel
    import cms_pkg::*;
#(
    parameter  int MESH     = 8,
    parameter  int AW       = 8,
    parameter  int INTERVAL = 100000,
    localparam int NCORE    = MESH * MESH,
    localparam int IDXW     = $clog2(NCORE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_wr_en,
    input  logic [IDXW-1:0] act_wr_core,
    input  logic [AW-1:0]   act_wr_value,
    output logic            interval_end,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic [IDXW-1:0] cmd_src,
    output logic [IDXW-1:0] cmd_dst,
    output logic            overrun
);
    localparam int BAND  = MESH / 4;
    localparam int NCENT = (MESH - 2 * BAND) * (MESH - 2 * BAND);
    localparam int SW    = $clog2(NCENT);

    cms_state_e state_q, state_d;

    logic [NCORE-1:0][AW-1:0] work;
    logic [NCORE-1:0]         used;
    logic [SW-1:0]            step;
    logic [IDXW-1:0]          hot_idx, cold_idx;
    logic                     hot_found, cold_found;
    logic                     hotter, last, load;

    cms_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (interval_end)
    );

    assign load = (state_q == ST_IDLE) && interval_end;

    cms_act_store #(.NCORE(NCORE), .AW(AW), .IDXW(IDXW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (act_wr_en),
        .wr_idx (act_wr_core),
        .wr_val (act_wr_value),
        .load   (load),
        .work   (work)
    );

    cms_pick #(.MESH(MESH), .NCORE(NCORE), .AW(AW), .IDXW(IDXW)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .work       (work),
        .used       (used),
        .region_sel (step[1:0]),
        .hot_idx    (hot_idx),
        .hot_found  (hot_found),
        .cold_idx   (cold_idx),
        .cold_found (cold_found)
    );

    assign hotter = hot_found && cold_found
                    && (cms_level(16'(work[hot_idx])) > cms_level(16'(work[cold_idx])));
    assign last   = (step == SW'(NCENT - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (interval_end) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_PICK;
            ST_PICK: begin
                if (hotter)    state_d = ST_ISSUE;
                else if (last) state_d = ST_IDLE;
                else           state_d = ST_PICK;
            end
            ST_ISSUE: begin
                if (cmd_ready) state_d = last ? ST_IDLE : ST_PICK;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and selection bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_src   <= '0;
            cmd_dst   <= '0;
            used      <= '0;
            step      <= '0;
            overrun   <= 1'b0;
        end else begin
            overrun <= interval_end && (state_q != ST_IDLE);
            unique case (state_q)
                ST_IDLE: ;
                ST_LOAD: begin
                    used <= '0;
                    step <= '0;
                end
                ST_PICK: begin
                    used[hot_idx] <= 1'b1;
                    if (hotter) begin
                        cmd_valid      <= 1'b1;
                        cmd_src        <= hot_idx;
                        cmd_dst        <= cold_idx;
                        used[cold_idx] <= 1'b1;
                    end else if (!last) begin
                        step <= step + 1'b1;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        cmd_valid <= 1'b0;
                        if (!last) step <= step + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst)); // R8

    AST_CMD_HOTTER: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cms_level(16'(work[cmd_src])) > cms_level(16'(work[cmd_dst])))); // R6

    AST_CMD_PLACEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cms_is_central(int'(cmd_src), MESH)
                      && !cms_is_central(int'(cmd_dst), MESH)); // R2

    AST_OVERRUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (state_q != ST_LOAD)); // R11

    AST_VALID_IN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (state_q == ST_ISSUE)); // R12

endmodule

// File: tb/clockwise_mig_sel_bench.sv
module clockwise_mig_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IVL        = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_wr_en = 1'b0;
    logic [5:0] act_wr_core = '0;
    logic [7:0] act_wr_value = '0;
    logic       interval_end, cmd_valid, cmd_ready, overrun;
    logic [5:0] cmd_src, cmd_dst;

    int n_checks = 0;
    int n_fail   = 0;
    int mir[64];
    logic [11:0] expq[$];
    int rmode = 0;
    int cyc = 0;
    int n_acc = 0;
    int n_overrun = 0;
    int last_tick = -1;
    logic       prv_hold = 1'b0;
    logic [5:0] prv_src = '0, prv_dst = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clockwise_mig_sel #(.MESH(8), .AW(8), .INTERVAL(IVL)) u_clockwise_mig_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_wr_en    (act_wr_en),
        .act_wr_core  (act_wr_core),
        .act_wr_value (act_wr_value),
        .interval_end (interval_end),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_src      (cmd_src),
        .cmd_dst      (cmd_dst),
        .overrun      (overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Floorplan per R2
    function automatic bit b_central(input int i);
        int r, c;
        r = i / 8; c = i % 8;
        return r >= 2 && r <= 5 && c >= 2 && c <= 5;
    endfunction

    function automatic int b_region(input int i);
        int r, c;
        r = i / 8; c = i % 8;
        if (r <= 1 && c <= 5) return 0;
        if (c >= 6 && r <= 5) return 1;
        if (r >= 6 && c >= 2) return 2;
        return 3;
    endfunction

    // Levels per R3
    function automatic int b_level(input int a);
        if (a >= 20) return 4;
        if (a >= 15) return 3;
        if (a >= 10) return 2;
        if (a >= 5)  return 1;
        return 0;
    endfunction

    // Expected command list per R4..R7, R12
    task automatic build_expect();
        bit u[64];
        for (int i = 0; i < 64; i++) u[i] = 0;
        for (int k = 0; k < 16; k++) begin
            int h, c;
            h = -1; c = -1;
            for (int i = 0; i < 64; i++)
                if (b_central(i) && !u[i] && (h < 0 || mir[i] > mir[h])) h = i;
            for (int i = 0; i < 64; i++)
                if (!b_central(i) && b_region(i) == k % 4 && !u[i] && (c < 0 || mir[i] < mir[c])) c = i;
            u[h] = 1;
            if (b_level(mir[h]) > b_level(mir[c])) begin
                u[c] = 1;
                expq.push_back({6'(h), 6'(c)});
            end
        end
    endtask

    task automatic write_all();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            act_wr_en    = 1'b1;
            act_wr_core  = 6'(i);
            act_wr_value = 8'(mir[i]);
        end
        @(negedge clk);
        act_wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!interval_end) @(negedge clk);
    endtask

    // One full evaluation: tick, expected list, drain, empty-queue check
    task automatic run_interval(input string req);
        int acc0;
        wait_tick();
        acc0 = n_acc;
        build_expect();
        repeat (100) @(negedge clk);
        check(expq.size() == 0, req, expq.size(), 0);
        check(!cmd_valid, req, int'(cmd_valid), 0);
    endtask

    // Ready driver, changes just after the edge
    always @(posedge clk) begin
        #1;
        cyc <= cyc + 1;
        case (rmode)
            0: cmd_ready <= 1'b1;
            1: cmd_ready <= (cyc % 3) != 0;
            default: cmd_ready <= 1'b0;
        endcase
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prv_hold) begin
                check(cmd_valid && cmd_src == prv_src && cmd_dst == prv_dst,
                      "R8 hold", {cmd_src, cmd_dst}, {prv_src, prv_dst});
            end
            prv_hold = cmd_valid && !cmd_ready;
            prv_src  = cmd_src;
            prv_dst  = cmd_dst;
            if (cmd_valid && cmd_ready) begin
                n_acc++;
                if (expq.size() == 0) begin
                    check(1'b0, "R6 unexpected command", {cmd_src, cmd_dst}, 0);
                end else begin
                    logic [11:0] e;
                    e = expq.pop_front();
                    check({cmd_src, cmd_dst} == e, "R4/R5 command order", {cmd_src, cmd_dst}, e);
                end
            end
            if (overrun) n_overrun++;
            if (interval_end) begin
                if (last_tick >= 0)
                    check(cyc - last_tick == IVL, "R10 period", cyc - last_tick, IVL);
                last_tick = cyc;
            end
        end
    end

    initial begin
        int acc0;
        cmd_ready = 1'b1;
        for (int i = 0; i < 64; i++) mir[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid, "R1 reset valid", int'(cmd_valid), 0);
        check(!overrun, "R1 reset overrun", int'(overrun), 0);

        // R1: no reports -> no command
        acc0 = n_acc;
        run_interval("R1 empty interval");
        check(n_acc == acc0, "R1 no commands", n_acc - acc0, 0);

        // R3 boundary: one central at 5 (level 1), its peer at 4, ring at 4
        for (int i = 0; i < 64; i++) mir[i] = b_central(i) ? 0 : 4;
        mir[18] = 5; mir[19] = 4;
        write_all();
        acc0 = n_acc;
        run_interval("R3 boundary");
        check(n_acc - acc0 == 1, "R3 single swap", n_acc - acc0, 1);

        // R3 upper boundary: central 9 vs ring 5 are both level 1
        for (int i = 0; i < 64; i++) mir[i] = b_central(i) ? 9 : 5;
        write_all();
        acc0 = n_acc;
        run_interval("R6 equal level");
        check(n_acc == acc0, "R6 no swap at equal level", n_acc - acc0, 0);

        // R7/R12: all central hot, all ring cold, ties everywhere
        for (int i = 0; i < 64; i++) mir[i] = b_central(i) ? 30 : 0;
        write_all();
        acc0 = n_acc;
        run_interval("R7 ties");
        check(n_acc - acc0 == 16, "R12 sixteen swaps", n_acc - acc0, 16);

        // R4/R5 mixed pattern with a throttled consumer
        for (int i = 0; i < 64; i++) mir[i] = b_central(i) ? (i * 7) % 29 : (i * 5) % 13;
        write_all();
        rmode = 1;
        run_interval("R5 mixed");
        rmode = 0;

        // R9/R11: stall across a tick, rewrite reports meanwhile
        for (int i = 0; i < 64; i++) mir[i] = b_central(i) ? 25 - (i % 4) : i % 3;
        write_all();
        rmode = 2;
        wait_tick();
        build_expect();
        check(n_overrun == 0, "R11 no early overrun", n_overrun, 0);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 64; i++) mir[i] = b_central(i) ? (i == 34 ? 12 : 0) : 3;
        write_all();
        wait_tick();
        @(negedge clk);
        check(overrun == 1'b1, "R11 overrun pulse", int'(overrun), 1);
        check(cmd_valid, "R8 still held", int'(cmd_valid), 1);
        @(negedge clk);
        check(!overrun, "R11 overrun one cycle", int'(overrun), 0);
        rmode = 0;
        repeat (100) @(negedge clk);
        check(expq.size() == 0, "R9 old reports drained", expq.size(), 0);
        check(n_overrun == 1, "R11 overrun count", n_overrun, 1);
        acc0 = n_acc;
        run_interval("R9 new reports");
        check(n_acc - acc0 == 1, "R9 new list length", n_acc - acc0, 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule